// File: doc/BRIEF.md
# External Bus Port-Sizing Controller

This block is a synchronous master for a narrow external bus. It accepts one internal access at a time. An access carries an address, an operand size (byte, word or longword), a direction and write data. The block replays the access as one or more external bus cycles ("beats") sized to the data port of the device behind the chosen chip select.

Narrow devices sit on the upper byte lanes. An 8-bit device uses data bits 31:24, and a 16-bit device uses bits 31:16. Operands are carried big-endian, so the most significant byte goes out on the first beat.

Each chip-select region is described by:
- a base and a compare mask,
- an enable,
- a port width,
- a wait-state count,
- an internal-termination flag.

When the flag is set, a beat lasts a fixed number of clocks. When it is clear, a beat waits for the external acknowledge. An address that falls in no region is refused at once with an error response, and no bus cycle is run.

Address, transfer start, direction, size, transfer-in-progress and write data change on the rising clock edge. Chip selects, output enable and byte strobes change on the falling edge. Read data is sampled on the rising edge that closes each beat. Operands are assumed naturally aligned.

Top module: `ebus_sizer`

## Requirements
- R1: While reset is high and after its release, all chip selects, output enable and byte strobes are high (negated), bus_ts, bus_tip and rsp_done are low, and req_ready is high.
- R2: Region i matches when cfg_en[i] is set and ((addr ^ base_i) & mask_i) == 0. When several regions match, the lowest index wins. With no match, rsp_done and rsp_err are high in the cycle after acceptance, and no bus_ts or chip select is asserted.
- R3: Size encodings are 2'b01 byte, 2'b10 word and 2'b00 longword. Port encodings are 2'b01 8-bit, 2'b10 16-bit and 2'b00 32-bit. An access makes max(1, operand bytes / port bytes) beats.
- R4: Byte lane 3 is bus bits 31:24 and bus_bs_n[3].
  - An 8-bit port uses lane 3 only.
  - A 16-bit port uses lanes 3..2, with an odd-address byte on lane 2.
  - A 32-bit port places address offset 0 on lane 3.
  - Read data returns right-justified in rsp_rdata, first beat most significant.
- R5: bus_ts is high for exactly the first clock of each beat, and bus_addr advances by the port width in bytes from one beat to the next.
- R6: With internal termination, every beat lasts wait-states + 1 clocks, and bus_ta_n has no effect.
- R7: Without internal termination, a beat ends at the rising edge where bus_ta_n is sampled low.
- R8: bus_tip stays high from the first beat to the end of the last. rsp_done is a one-cycle pulse in the cycle after the final beat ends. req_ready is low while a transfer runs.
- R9: Chip selects, output enable and byte strobes assert on the falling edge inside the first clock of an access. They are still negated just after the rising edge that starts it.
- R10: Reads drive bus_rw high and assert bus_oe_n. Writes drive bus_rw low, keep bus_oe_n negated and raise bus_dout_en. bus_siz carries the operand size code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_base | input | NUM_CS*ADDR_W | Region base addresses, region 0 in the low bits |
| cfg_mask | input | NUM_CS*ADDR_W | Region compare masks (1 = bit compared) |
| cfg_en | input | NUM_CS | Region enables |
| cfg_port | input | NUM_CS*2 | Region port width codes |
| cfg_ws | input | NUM_CS*WS_W | Region wait-state counts |
| cfg_int_term | input | NUM_CS | Region internal-termination flags |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Block idle, request accepted |
| req_addr | input | ADDR_W | Access byte address |
| req_size | input | 2 | Operand size code |
| req_write | input | 1 | 1 = write |
| req_wdata | input | DATA_W | Write operand, right-justified |
| rsp_done | output | 1 | Access finished pulse |
| rsp_err | output | 1 | Address matched no region |
| rsp_rdata | output | DATA_W | Assembled read operand |
| bus_addr | output | ADDR_W | External address |
| bus_ts | output | 1 | Transfer start, one clock per beat |
| bus_rw | output | 1 | 1 = read, 0 = write |
| bus_siz | output | 2 | Operand size code |
| bus_tip | output | 1 | Transfer in progress |
| bus_cs_n | output | NUM_CS | Chip selects, active low |
| bus_oe_n | output | 1 | Output enable, active low |
| bus_bs_n | output | DATA_W/8 | Byte strobes, active low |
| bus_dout | output | DATA_W | Write data |
| bus_dout_en | output | 1 | Write data drive enable |
| bus_din | input | DATA_W | Read data |
| bus_ta_n | input | 1 | External acknowledge, active low |

## Verification
In an internally terminated region, the local wait-state countdown and the external acknowledge can both fall in the same clock. The slave model therefore toggles bus_ta_n at random for every clock of every beat in such regions, including the clock where the countdown expires and clocks well before it. The bench judges the collision by the total latency from acceptance to rsp_done: it must equal beats × (wait states + 1) + 1, whatever the acknowledge did. For acknowledge-terminated regions, the bench adds up its own random acknowledge delays and expects the latency to match that sum.

// File: rtl/ebus_pkg.sv
package ebus_pkg;

  typedef enum logic [1:0] {
    OP_LONG = 2'b00,
    OP_BYTE = 2'b01,
    OP_WORD = 2'b10,
    OP_RSVD = 2'b11
  } op_size_e;

  typedef enum logic [1:0] {
    PORT_32   = 2'b00,
    PORT_8    = 2'b01,
    PORT_16   = 2'b10,
    PORT_RSVD = 2'b11
  } port_size_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BEAT = 1'b1
  } ctl_state_e;

  // bytes in an operand
  function automatic logic [2:0] op_bytes(input logic [1:0] code);
    case (code)
      OP_BYTE: op_bytes = 3'd1;
      OP_WORD: op_bytes = 3'd2;
      default: op_bytes = 3'd4;
    endcase
  endfunction

  // bytes carried per beat by a port
  function automatic logic [2:0] port_bytes(input logic [1:0] code);
    case (code)
      PORT_8:  port_bytes = 3'd1;
      PORT_16: port_bytes = 3'd2;
      default: port_bytes = 3'd4;
    endcase
  endfunction

  // number of beats for an operand on a port
  function automatic logic [2:0] beat_count(input logic [2:0] ob, input logic [2:0] pb);
    if (ob <= pb)       beat_count = 3'd1;
    else if (pb == 3'd1) beat_count = ob;
    else                beat_count = ob >> 1;
  endfunction

endpackage

// File: rtl/ebus_cs_decode.sv
module ebus_cs_decode #(
  parameter int NUM_CS = 4,
  parameter int ADDR_W = 24,
  parameter int WS_W   = 4,
  parameter int IDX_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic [ADDR_W-1:0]        addr,
  input  logic [NUM_CS*ADDR_W-1:0] cfg_base,
  input  logic [NUM_CS*ADDR_W-1:0] cfg_mask,
  input  logic [NUM_CS-1:0]        cfg_en,
  input  logic [NUM_CS*2-1:0]      cfg_port,
  input  logic [NUM_CS*WS_W-1:0]   cfg_ws,
  input  logic [NUM_CS-1:0]        cfg_int_term,
  output logic                     hit,
  output logic [IDX_W-1:0]         idx,
  output logic [1:0]               port,
  output logic [WS_W-1:0]          ws,
  output logic                     int_term
);

  logic [NUM_CS-1:0] match;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_match
    assign match[g] = cfg_en[g] &&
      (((addr ^ cfg_base[g*ADDR_W +: ADDR_W]) & cfg_mask[g*ADDR_W +: ADDR_W]) == '0);
  end

  // lowest index has priority: scan downward so it is written last
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = NUM_CS - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

  assign port     = cfg_port[idx*2 +: 2];
  assign ws       = cfg_ws[idx*WS_W +: WS_W];
  assign int_term = cfg_int_term[idx];

endmodule

// File: rtl/ebus_lane.sv
module ebus_lane #(
  parameter int DATA_W = 32,
  parameter int LANES  = DATA_W / 8,
  parameter int OFF_W  = $clog2(LANES),
  parameter int BW_W   = OFF_W + 1
) (
  input  logic [DATA_W-1:0] shreg,
  input  logic [OFF_W-1:0]  off,
  input  logic [BW_W-1:0]   bw,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic [LANES-1:0]  lanes,
  output logic [DATA_W-1:0] rd_part
);

  logic [LANES-1:0]  lanes_top;
  logic [OFF_W+2:0]  off_bits;
  logic [BW_W+2:0]   bw_bits;

  always_comb begin
    off_bits  = {off, 3'b000};
    bw_bits   = {bw, 3'b000};
    // operand is left-justified in shreg; slide it down to its lane offset
    dout      = shreg >> off_bits;
    // bw lanes counted from the top, then moved to the offset
    lanes_top = ~({LANES{1'b1}} >> bw);
    lanes     = lanes_top >> off;
    // pick bw bytes starting at the offset lane, right-justified
    rd_part   = (din << off_bits) >> (DATA_W - int'(bw_bits));
  end

endmodule

// File: rtl/ebus_strobe.sv
module ebus_strobe #(
  parameter int NUM_CS = 4,
  parameter int LANES  = 4,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              rd,
  input  logic [IDX_W-1:0]  sel,
  input  logic [LANES-1:0]  lanes,
  output logic [NUM_CS-1:0] cs_n,
  output logic              oe_n,
  output logic [LANES-1:0]  bs_n
);

  logic [NUM_CS-1:0] sel_hot;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_sel
    assign sel_hot[g] = active && (sel == IDX_W'(g));
  end

  // falling-edge launch, half a clock after the rising-edge state
  always_ff @(negedge clk) begin
    if (rst) begin
      cs_n <= '1;
      oe_n <= 1'b1;
      bs_n <= '1;
    end else begin
      cs_n <= ~sel_hot;
      oe_n <= ~(active && rd);
      bs_n <= active ? ~lanes : '1;
    end
  end

endmodule

// File: rtl/ebus_sizer.sv
module ebus_sizer
  import ebus_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int NUM_CS = 4,
  parameter int WS_W   = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_CS*ADDR_W-1:0] cfg_base,
  input  logic [NUM_CS*ADDR_W-1:0] cfg_mask,
  input  logic [NUM_CS-1:0]        cfg_en,
  input  logic [NUM_CS*2-1:0]      cfg_port,
  input  logic [NUM_CS*WS_W-1:0]   cfg_ws,
  input  logic [NUM_CS-1:0]        cfg_int_term,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [1:0]               req_size,
  input  logic                     req_write,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     rsp_done,
  output logic                     rsp_err,
  output logic [DATA_W-1:0]        rsp_rdata,
  output logic [ADDR_W-1:0]        bus_addr,
  output logic                     bus_ts,
  output logic                     bus_rw,
  output logic [1:0]               bus_siz,
  output logic                     bus_tip,
  output logic [NUM_CS-1:0]        bus_cs_n,
  output logic                     bus_oe_n,
  output logic [DATA_W/8-1:0]      bus_bs_n,
  output logic [DATA_W-1:0]        bus_dout,
  output logic                     bus_dout_en,
  input  logic [DATA_W-1:0]        bus_din,
  input  logic                     bus_ta_n
);

  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);
  localparam int BW_W  = OFF_W + 1;
  localparam int IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

  // decode results
  logic             dec_hit;
  logic [IDX_W-1:0] dec_idx;
  logic [1:0]       dec_port;
  logic [WS_W-1:0]  dec_ws;
  logic             dec_int;

  // transfer state
  ctl_state_e       state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] shreg_q;
  logic [DATA_W-1:0] acc_q;
  logic [BW_W-1:0]  beats_q;
  logic [BW_W-1:0]  pb_q;
  logic [BW_W-1:0]  bw_q;
  logic [WS_W-1:0]  ws_q;
  logic [WS_W-1:0]  cnt_q;
  logic             aa_q;
  logic [IDX_W-1:0] sel_q;
  logic             rw_q;
  logic [1:0]       siz_q;
  logic             ts_q;
  logic             tip_q;
  logic             done_q;
  logic             err_q;
  logic [DATA_W-1:0] rdata_q;

  // lane steering
  logic [OFF_W-1:0]  off;
  logic [DATA_W-1:0] lane_dout;
  logic [LANES-1:0]  lane_sel;
  logic [DATA_W-1:0] rd_part;
  logic [DATA_W-1:0] acc_next;
  logic [BW_W+2:0]   bw_bits;

  // request-side derived values
  logic [BW_W-1:0]  ob_n;
  logic [BW_W-1:0]  pb_n;
  logic [BW_W-1:0]  bw_n;
  logic [BW_W+2:0]  ob_bits;

  logic beat_active;
  logic beat_end;

  ebus_cs_decode #(
    .NUM_CS (NUM_CS),
    .ADDR_W (ADDR_W),
    .WS_W   (WS_W),
    .IDX_W  (IDX_W)
  ) u_dec (
    .addr         (req_addr),
    .cfg_base     (cfg_base),
    .cfg_mask     (cfg_mask),
    .cfg_en       (cfg_en),
    .cfg_port     (cfg_port),
    .cfg_ws       (cfg_ws),
    .cfg_int_term (cfg_int_term),
    .hit          (dec_hit),
    .idx          (dec_idx),
    .port         (dec_port),
    .ws           (dec_ws),
    .int_term     (dec_int)
  );

  assign beat_active = (state_q == ST_BEAT);
  // byte offset of the current beat inside the port
  assign off      = addr_q[OFF_W-1:0] & (pb_q[OFF_W-1:0] - 1'b1);
  assign beat_end = beat_active && (aa_q ? (cnt_q == '0) : !bus_ta_n);

  ebus_lane #(
    .DATA_W (DATA_W),
    .LANES  (LANES),
    .OFF_W  (OFF_W),
    .BW_W   (BW_W)
  ) u_lane (
    .shreg   (shreg_q),
    .off     (off),
    .bw      (bw_q),
    .din     (bus_din),
    .dout    (lane_dout),
    .lanes   (lane_sel),
    .rd_part (rd_part)
  );

  always_comb begin
    ob_n     = op_bytes(req_size);
    pb_n     = port_bytes(dec_port);
    bw_n     = (ob_n < pb_n) ? ob_n : pb_n;
    ob_bits  = {ob_n, 3'b000};
    bw_bits  = {bw_q, 3'b000};
    acc_next = (acc_q << bw_bits) | rd_part;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      shreg_q <= '0;
      acc_q   <= '0;
      beats_q <= '0;
      pb_q    <= BW_W'(LANES);
      bw_q    <= BW_W'(LANES);
      ws_q    <= '0;
      cnt_q   <= '0;
      aa_q    <= 1'b0;
      sel_q   <= '0;
      rw_q    <= 1'b1;
      siz_q   <= OP_LONG;
      ts_q    <= 1'b0;
      tip_q   <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ts_q   <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            if (!dec_hit) begin
              done_q  <= 1'b1;
              err_q   <= 1'b1;
              rdata_q <= '0;
            end else begin
              state_q <= ST_BEAT;
              addr_q  <= req_addr;
              // left-justify the operand so the MSB goes out first
              shreg_q <= req_wdata << (DATA_W - int'(ob_bits));
              acc_q   <= '0;
              beats_q <= beat_count(ob_n, pb_n);
              pb_q    <= pb_n;
              bw_q    <= bw_n;
              ws_q    <= dec_ws;
              cnt_q   <= dec_ws;
              aa_q    <= dec_int;
              sel_q   <= dec_idx;
              rw_q    <= !req_write;
              siz_q   <= req_size;
              ts_q    <= 1'b1;
              tip_q   <= 1'b1;
            end
          end
        end
        ST_BEAT: begin
          if (beat_end) begin
            acc_q <= acc_next;
            if (beats_q == BW_W'(1)) begin
              state_q <= ST_IDLE;
              tip_q   <= 1'b0;
              done_q  <= 1'b1;
              rdata_q <= acc_next;
            end else begin
              beats_q <= beats_q - 1'b1;
              addr_q  <= addr_q + ADDR_W'(pb_q);
              shreg_q <= shreg_q << bw_bits;
              cnt_q   <= ws_q;
              ts_q    <= 1'b1;
            end
          end else if (aa_q) begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  ebus_strobe #(
    .NUM_CS (NUM_CS),
    .LANES  (LANES),
    .IDX_W  (IDX_W)
  ) u_strb (
    .clk    (clk),
    .rst    (rst),
    .active (beat_active),
    .rd     (rw_q),
    .sel    (sel_q),
    .lanes  (lane_sel),
    .cs_n   (bus_cs_n),
    .oe_n   (bus_oe_n),
    .bs_n   (bus_bs_n)
  );

  assign req_ready   = (state_q == ST_IDLE);
  assign rsp_done    = done_q;
  assign rsp_err     = err_q;
  assign rsp_rdata   = rdata_q;
  assign bus_addr    = addr_q;
  assign bus_ts      = ts_q;
  assign bus_rw      = rw_q;
  assign bus_siz     = siz_q;
  assign bus_tip     = tip_q;
  assign bus_dout    = lane_dout;
  assign bus_dout_en = beat_active && !rw_q;

endmodule

// File: rtl/ebus_sizer_chk.sv
module ebus_sizer_chk #(
  parameter int ADDR_W = 24,
  parameter int WS_W   = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              rsp_done,
  input logic              rsp_err,
  input logic              bus_ts,
  input logic              bus_tip,
  input logic              bus_rw,
  input logic              bus_oe_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              aa_q,
  input logic [WS_W-1:0]   ws_q
);

  // clocks already spent in the current beat, counted from its second clock
  logic [WS_W:0] beat_cyc;

  always_ff @(posedge clk) begin
    if (rst)          beat_cyc <= '0;
    else if (bus_ts)  beat_cyc <= (WS_W+1)'(1);
    else if (bus_tip && beat_cyc != '1) beat_cyc <= beat_cyc + 1'b1;
  end

  // R8: busy transfer blocks new requests
  a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
    bus_tip |-> !req_ready);

  // R8: completion is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

  // R2: an error response never comes with a bus cycle
  a_r2_err_no_cycle: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (rsp_done && !bus_tip && !bus_ts));

  // R5: a following beat presents a new address
  a_r5_addr_moves: assert property (@(posedge clk) disable iff (rst)
    (bus_ts && $past(bus_tip) && bus_tip) |-> (bus_addr != $past(bus_addr)));

  // R6: internally terminated beats never outlast wait states + 1 clocks
  a_r6_beat_len: assert property (@(posedge clk) disable iff (rst)
    (bus_tip && !bus_ts && aa_q) |-> (beat_cyc <= {1'b0, ws_q}));

  // R10: output enable only during reads
  a_r10_oe_read_only: assert property (@(posedge clk) disable iff (rst)
    !bus_oe_n |-> bus_rw);

endmodule

bind ebus_sizer ebus_sizer_chk #(
  .ADDR_W (ADDR_W),
  .WS_W   (WS_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_ready (req_ready),
  .rsp_done  (rsp_done),
  .rsp_err   (rsp_err),
  .bus_ts    (bus_ts),
  .bus_tip   (bus_tip),
  .bus_rw    (bus_rw),
  .bus_oe_n  (bus_oe_n),
  .bus_addr  (bus_addr),
  .aa_q      (aa_q),
  .ws_q      (ws_q)
);

// File: tb/sim_ebus_sizer.sv
module sim_ebus_sizer;

  localparam int AW = 24;
  localparam int DW = 32;
  localparam int NC = 4;
  localparam int WW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  // bench view of the region setup
  logic [AW-1:0] bb [NC];
  logic [AW-1:0] bm [NC];
  int pb_of [NC] = '{1, 2, 4, 4};
  int ws_of [NC] = '{1, 0, 2, 0};
  int it_of [NC] = '{1, 0, 1, 0};

  logic [NC*AW-1:0] cfg_base, cfg_mask;
  logic [NC-1:0]    cfg_en = 4'b1111;
  logic [NC*2-1:0]  cfg_port = {2'b00, 2'b00, 2'b10, 2'b01};
  logic [NC*WW-1:0] cfg_ws = {4'd0, 4'd2, 4'd0, 4'd1};
  logic [NC-1:0]    cfg_int_term = 4'b0101;

  always_comb begin
    for (int i = 0; i < NC; i++) begin
      cfg_base[i*AW +: AW] = bb[i];
      cfg_mask[i*AW +: AW] = bm[i];
    end
  end

  logic          req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_size = 2'b00;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_done, rsp_err;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] bus_addr;
  logic          bus_ts, bus_rw, bus_tip, bus_oe_n, bus_dout_en;
  logic [1:0]    bus_siz;
  logic [NC-1:0] bus_cs_n;
  logic [3:0]    bus_bs_n;
  logic [DW-1:0] bus_dout, bus_din;
  logic          bus_ta_n = 1'b1;

  ebus_sizer u0 (
    .clk(clk), .rst(rst),
    .cfg_base(cfg_base), .cfg_mask(cfg_mask), .cfg_en(cfg_en),
    .cfg_port(cfg_port), .cfg_ws(cfg_ws), .cfg_int_term(cfg_int_term),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .bus_addr(bus_addr), .bus_ts(bus_ts), .bus_rw(bus_rw), .bus_siz(bus_siz),
    .bus_tip(bus_tip), .bus_cs_n(bus_cs_n), .bus_oe_n(bus_oe_n),
    .bus_bs_n(bus_bs_n), .bus_dout(bus_dout), .bus_dout_en(bus_dout_en),
    .bus_din(bus_din), .bus_ta_n(bus_ta_n)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // slave memory and an independent reference image
  logic [7:0] smem [2048];
  logic [7:0] rmem [2048];
  logic [31:0] junk = 32'h5AC3_91E7;

  function automatic int mi(input logic [AW-1:0] a);
    return int'({a[22:20], a[7:0]});
  endfunction

  function automatic int active_cs();
    for (int i = 0; i < NC; i++) if (!bus_cs_n[i]) return i;
    return -1;
  endfunction

  // read data: the slave's port width decides which lanes carry bytes
  always_comb begin
    int c;
    int p;
    logic [AW-1:0] base;
    c = active_cs();
    bus_din = junk;
    if (c >= 0) begin
      p = pb_of[c];
      base = bus_addr & ~AW'(p - 1);
      for (int k = 0; k < p; k++)
        bus_din[31-8*k -: 8] = smem[mi(base + AW'(k))];
    end
  end

  always @(posedge clk) junk <= {junk[30:0], junk[31] ^ junk[21] ^ junk[1] ^ junk[0]};

  int tcnt = 0;
  int ta_total = 0;

  // slave: writes and acknowledge, acting mid low phase
  always @(negedge clk) begin
    int c;
    logic [AW-1:0] base;
    #1;
    c = active_cs();
    if (c < 0) begin
      bus_ta_n = 1'b1;
    end else begin
      if (!bus_rw && bus_dout_en) begin
        base = bus_addr & ~AW'(pb_of[c] - 1);
        for (int l = 0; l < 4; l++)
          if (!bus_bs_n[l]) smem[mi(base + AW'(3 - l))] = bus_dout[8*l +: 8];
      end
      if (it_of[c] != 0) begin
        bus_ta_n = 1'($urandom % 2);   // noise that must be ignored
      end else begin
        if (bus_ts) begin
          tcnt = int'($urandom % 3);
          ta_total += tcnt + 1;
        end else if (tcnt > 0) begin
          tcnt--;
        end
        bus_ta_n = (tcnt == 0) ? 1'b0 : 1'b1;
      end
    end
  end

  function automatic int ob_of(input logic [1:0] s);
    return (s == 2'b01) ? 1 : (s == 2'b10) ? 2 : 4;
  endfunction

  task automatic run_op(input logic [AW-1:0] a, input logic [1:0] sz, input bit wr, input logic [31:0] wd);
    int sel;
    int ob;
    int beats;
    int n;
    int tsn;
    int lat;
    logic [31:0] expv;
    sel = -1;
    for (int i = NC - 1; i >= 0; i--)
      if (cfg_en[i] && (((a ^ bb[i]) & bm[i]) == '0)) sel = i;
    ob = ob_of(sz);
    beats = (sel < 0) ? 0 : ((ob <= pb_of[sel]) ? 1 : ob / pb_of[sel]);
    expv = 0;
    for (int k = 0; k < ob; k++) expv = (expv << 8) | 32'(rmem[mi(a + AW'(k))]);
    if (wr && sel >= 0)
      for (int k = 0; k < ob; k++) rmem[mi(a + AW'(k))] = 8'(wd >> (8 * (ob - 1 - k)));

    @(negedge clk);
    req_addr = a; req_size = sz; req_write = wr; req_wdata = wd; req_valid = 1'b1;
    ta_total = 0;
    @(posedge clk);
    #1;
    if (sel >= 0) begin
      chk(bus_ts == 1'b1, "R5 ts at first clock", 32'(bus_ts), 1);
      chk(bus_cs_n == '1, "R9 strobes still negated after rising edge", 32'(bus_cs_n), 32'hF);
      chk(bus_rw == !wr, "R10 direction", 32'(bus_rw), 32'(!wr));
      chk(bus_siz == sz, "R10 size code", 32'(bus_siz), 32'(sz));
      chk(bus_addr == a, "R5 first address", 32'(bus_addr), 32'(a));
    end
    @(negedge clk);
    req_valid = 1'b0;
    n = 1;
    tsn = 0;
    forever begin
      #1;
      if (bus_ts) tsn++;
      if (rsp_done) break;
      chk(bus_tip == 1'b1, "R8 tip held", 32'(bus_tip), 1);
      chk(req_ready == 1'b0, "R8 not ready while busy", 32'(req_ready), 0);
      if (sel >= 0) begin
        chk(bus_cs_n == ~(4'b1 << sel), "R2 chosen chip select", 32'(bus_cs_n), 32'(~(4'b1 << sel)));
        chk(bus_oe_n == wr, "R10 output enable", 32'(bus_oe_n), 32'(wr));
        if (pb_of[sel] == 1)
          chk(bus_bs_n[2:0] == 3'b111, "R4 8-bit port uses lane 3 only", 32'(bus_bs_n), 32'h7);
      end
      n++;
      @(negedge clk);
    end
    if (sel < 0) begin
      chk(rsp_err == 1'b1, "R2 error flag", 32'(rsp_err), 1);
      chk(n == 1, "R2 immediate error", 32'(n), 1);
      chk(tsn == 0, "R2 no bus cycle", 32'(tsn), 0);
      chk(bus_cs_n == '1, "R2 no chip select", 32'(bus_cs_n), 32'hF);
    end else begin
      chk(rsp_err == 1'b0, "R2 no error on hit", 32'(rsp_err), 0);
      chk(tsn == beats, "R3 beat count", 32'(tsn), 32'(beats));
      lat = (it_of[sel] != 0) ? beats * (ws_of[sel] + 1) : ta_total;
      if (it_of[sel] != 0)
        chk(n == lat + 1, "R6 internal termination latency", 32'(n), 32'(lat + 1));
      else
        chk(n == lat + 1, "R7 acknowledge latency", 32'(n), 32'(lat + 1));
      chk(bus_tip == 1'b0, "R8 tip dropped at done", 32'(bus_tip), 0);
      if (!wr) begin
        chk(rsp_rdata == expv, "R4 read assembly", rsp_rdata, expv);
      end else begin
        for (int k = 0; k < ob; k++)
          chk(smem[mi(a + AW'(k))] == rmem[mi(a + AW'(k))], "R4 written byte lane",
              32'(smem[mi(a + AW'(k))]), 32'(rmem[mi(a + AW'(k))]));
      end
    end
    @(negedge clk);
    chk(rsp_done == 1'b0, "R8 done is one pulse", 32'(rsp_done), 0);
  endtask

  task automatic rand_op();
    int r;
    logic [1:0] sz;
    logic [AW-1:0] a;
    int ob;
    r = int'($urandom % 10);
    sz = 2'($urandom % 3);
    ob = ob_of(sz);
    a = AW'($urandom % 256) & ~AW'(ob - 1);
    if (r == 0) a[23:20] = 4'h5;
    else        a[23:20] = 4'(1 + (r % 4));
    run_op(a, sz, 1'($urandom % 2), $urandom);
  endtask

  initial begin
    #(8 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7331));
    bb[0] = 24'h100000; bb[1] = 24'h200000; bb[2] = 24'h300000; bb[3] = 24'h400000;
    for (int i = 0; i < NC; i++) bm[i] = 24'hF00000;
    for (int i = 0; i < 2048; i++) begin
      smem[i] = 8'(i * 7 + 3);
      rmem[i] = 8'(i * 7 + 3);
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    chk(bus_cs_n == '1 && bus_oe_n && bus_bs_n == '1, "R1 strobes in reset",
        32'({bus_cs_n, bus_oe_n, bus_bs_n}), 32'h1FF);
    rst = 1'b0;
    @(negedge clk);
    #1;
    chk(!bus_ts && !bus_tip && !rsp_done, "R1 idle outputs", 32'({bus_ts, bus_tip, rsp_done}), 0);
    chk(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 1);

    // directed corners
    run_op(24'h100010, 2'b00, 1'b0, 0);              // R3 longword over 8-bit: 4 beats
    run_op(24'h100020, 2'b10, 1'b1, 32'h0000BEEF);   // R3 word over 8-bit: 2 beats
    run_op(24'h200041, 2'b01, 1'b1, 32'h000000A7);   // R4 odd byte on 16-bit port, lane 2
    run_op(24'h200041, 2'b01, 1'b0, 0);
    run_op(24'h200044, 2'b00, 1'b1, 32'h1234_5678);  // R5 two beats, upper word first
    run_op(24'h200044, 2'b00, 1'b0, 0);
    run_op(24'h300013, 2'b01, 1'b1, 32'h0000005C);   // R4 offset 3 on 32-bit port
    run_op(24'h300012, 2'b10, 1'b0, 0);
    run_op(24'h400020, 2'b00, 1'b1, 32'hCAFE_F00D);  // R7 acknowledge-ended longword
    run_op(24'h000010, 2'b00, 1'b0, 0);              // R2 no region
    run_op(24'h500010, 2'b10, 1'b1, 32'h1111);       // R2 no region, write

    for (int i = 0; i < 300; i++) rand_op();

    // R2 priority: region 3 now matches everything, lower index still wins
    bm[3] = 24'h000000;
    run_op(24'h500010, 2'b01, 1'b0, 0);
    run_op(24'h100031, 2'b01, 1'b0, 0);
    run_op(24'h300030, 2'b00, 1'b0, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule